// File: doc/BRIEF.md
# Dual-Master GPIO Port with Alternate Functions

This block is a 7-pin general-purpose I/O port controller shared by two processor cores. A signal-processing core (the primary master) and a user core (the secondary master) each reach the port through their own register read/write strobes. Each core sees the same small register set: output data, direction and a read-only pin state.

Any pin may instead be claimed by an alternate-function peripheral. Examples are pulse-generator outputs, a clock output or SPI signals. A claim overrides both the output value and the output enable of that pin. The top two pins are permanent outputs. They reset high, and only the primary master may change them. For the secondary master those bits cannot be written and read back as zero.

Pin inputs pass through a two-flop synchronizer before they become readable. Pad pull-ups are modelled as one enable per pin.

Top module: `dual_gpio_port`

## Requirements
- R1: After reset the data register is 7'b1100000 and the direction register reads 7'b1100000. Pins 0 to 4 have pad_oe=0 and pad_pullup=1. Pins 5 and 6 have pad_oe=1 and pad_out=1.
- R2: The output enable of each pin is the OR of its direction bit (1 = output) and its alt_en bit. Pins 5 and 6 are always enabled, and their direction bits always read 1.
- R3: The driven value of each pin is alt_out[i] when alt_en[i] is 1, and the data register bit otherwise.
- R4: pad_pullup[i] is 1 exactly when pad_oe[i] is 0.
- R5: A secondary-master write leaves bits 5 and 6 of the data and direction registers unchanged. Every secondary-master read returns 0 in bits 5 and 6.
- R6: A primary-master write to address 0 (data) or address 1 (direction) updates all bits on the next clock edge, except the fixed direction bits 5 and 6. The value reads back the same through the primary master.
- R7: When both masters write the same register in one cycle, the primary master's value is stored. When they write different registers, both writes take effect.
- R8: Address 2 returns pad_in as sampled two clock edges earlier. A change is not visible after a single edge.
- R9: rdata is 0 while the read strobe is low. Address 3 reads as 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsp_wr | input | 1 | Primary-master write strobe |
| dsp_rd | input | 1 | Primary-master read strobe |
| dsp_addr | input | 2 | Primary-master register address (0 data, 1 direction, 2 pin state, 3 unused) |
| dsp_wdata | input | 7 | Primary-master write data |
| dsp_rdata | output | 7 | Primary-master read data |
| usr_wr | input | 1 | Secondary-master write strobe |
| usr_rd | input | 1 | Secondary-master read strobe |
| usr_addr | input | 2 | Secondary-master register address |
| usr_wdata | input | 7 | Secondary-master write data |
| usr_rdata | output | 7 | Secondary-master read data, bits 5 and 6 forced to 0 |
| alt_en | input | 7 | Per-pin alternate-function claim |
| alt_out | input | 7 | Per-pin alternate-function output value |
| pad_in | input | 7 | Pin input levels |
| pad_out | output | 7 | Pin output values |
| pad_oe | output | 7 | Pin output enables |
| pad_pullup | output | 7 | Pin pull-up enables |

## Verification
A corrupted data or direction bit shows up at pad_out, pad_oe and pad_pullup in the cycle right after the write that caused it. This is because the pad mux is combinational from the registers. A secondary-master write that leaks into the private bits changes pins 5 or 6 at once. A wrong priority in a write collision leaves the secondary master's value readable on the following read. A synchronizer that is too short or too long shows as a pin-state read that is one edge early or one edge late.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PINS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPIN  = 7,
    parameter int NPRIV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_wr,
    input  logic            a_rd,
    input  logic [1:0]      a_addr,
    input  logic [NPIN-1:0] a_wdata,
    output logic [NPIN-1:0] a_rdata,
    input  logic            b_wr,
    input  logic            b_rd,
    input  logic [1:0]      b_addr,
    input  logic [NPIN-1:0] b_wdata,
    output logic [NPIN-1:0] b_rdata,
    input  logic [NPIN-1:0] pins_q,
    output logic [NPIN-1:0] data_q,
    output logic [NPIN-1:0] dir_q
);
    localparam logic [NPIN-1:0] PRIV_MASK  = {{NPRIV{1'b1}}, {(NPIN-NPRIV){1'b0}}};
    localparam logic [NPIN-1:0] SHARE_MASK = ~PRIV_MASK;

    typedef struct packed {
        logic [NPIN-1:0] data;
        logic [NPIN-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;
    logic  a_data_wr, a_dir_wr, b_data_wr, b_dir_wr;

    always_comb begin
        a_data_wr = a_wr && (reg_sel_e'(a_addr) == SEL_DATA);
        a_dir_wr  = a_wr && (reg_sel_e'(a_addr) == SEL_DIR);
        b_data_wr = b_wr && (reg_sel_e'(b_addr) == SEL_DATA);
        b_dir_wr  = b_wr && (reg_sel_e'(b_addr) == SEL_DIR);
        r_d = r_q;
        // secondary master first, primary master overrides on collision
        if (b_data_wr) r_d.data = (r_q.data & PRIV_MASK) | (b_wdata & SHARE_MASK);
        if (b_dir_wr)  r_d.dir  = PRIV_MASK | (b_wdata & SHARE_MASK);
        if (a_data_wr) r_d.data = a_wdata;
        if (a_dir_wr)  r_d.dir  = PRIV_MASK | a_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.data <= PRIV_MASK;
            r_q.dir  <= PRIV_MASK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        a_rdata = '0;
        if (a_rd) begin
            case (reg_sel_e'(a_addr))
                SEL_DATA: a_rdata = r_q.data;
                SEL_DIR:  a_rdata = r_q.dir;
                SEL_PINS: a_rdata = pins_q;
                default:  a_rdata = '0;
            endcase
        end
        b_rdata = '0;
        if (b_rd) begin
            case (reg_sel_e'(b_addr))
                SEL_DATA: b_rdata = r_q.data & SHARE_MASK;
                SEL_DIR:  b_rdata = r_q.dir & SHARE_MASK;
                SEL_PINS: b_rdata = pins_q & SHARE_MASK;
                default:  b_rdata = '0;
            endcase
        end
    end

    assign data_q = r_q.data;
    assign dir_q  = r_q.dir;

    // R5: secondary-master data write never disturbs the private pins
    p_b_priv_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && reg_sel_e'(b_addr) == SEL_DATA && !(a_wr && reg_sel_e'(a_addr) == SEL_DATA))
        |=> ((r_q.data & PRIV_MASK) == ($past(r_q.data) & PRIV_MASK)));

    // R6: primary-master data write lands on the next edge
    p_a_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && reg_sel_e'(a_addr) == SEL_DATA) |=> (r_q.data == $past(a_wdata)));

    // R7: primary master wins a same-register collision
    p_a_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && b_wr && reg_sel_e'(a_addr) == SEL_DIR && reg_sel_e'(b_addr) == SEL_DIR)
        |=> ((r_q.dir & SHARE_MASK) == ($past(a_wdata) & SHARE_MASK)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPIN = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pins_q
);
    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
        logic [1:0]      warm;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.s1   = pad_in;
        s_d.s2   = s_q.s1;
        if (s_q.warm != 2'd2) s_d.warm = s_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pins_q = s_q.s2;

    // R8: readable pin state trails the pad by two edges
    p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warm == 2'd2) |-> (pins_q == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
    parameter int NPIN = 7
) (
    input  logic [NPIN-1:0] data_q,
    input  logic [NPIN-1:0] dir_q,
    input  logic [NPIN-1:0] alt_en,
    input  logic [NPIN-1:0] alt_out,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pullup
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            pad_oe[i]     = dir_q[i] | alt_en[i];
            pad_out[i]    = alt_en[i] ? alt_out[i] : data_q[i];
            pad_pullup[i] = ~pad_oe[i];
        end
    end
endmodule

// File: rtl/dual_gpio_port.sv
module dual_gpio_port #(
    parameter int NPIN  = 7,
    parameter int NPRIV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dsp_wr,
    input  logic            dsp_rd,
    input  logic [1:0]      dsp_addr,
    input  logic [NPIN-1:0] dsp_wdata,
    output logic [NPIN-1:0] dsp_rdata,
    input  logic            usr_wr,
    input  logic            usr_rd,
    input  logic [1:0]      usr_addr,
    input  logic [NPIN-1:0] usr_wdata,
    output logic [NPIN-1:0] usr_rdata,
    input  logic [NPIN-1:0] alt_en,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pullup
);
    localparam logic [NPIN-1:0] PRIV_MASK = {{NPRIV{1'b1}}, {(NPIN-NPRIV){1'b0}}};

    logic [NPIN-1:0] pins_q, data_q, dir_q;

    gpio_sync #(.NPIN(NPIN)) i_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pins_q(pins_q)
    );

    gpio_regs #(.NPIN(NPIN), .NPRIV(NPRIV)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .a_wr(dsp_wr), .a_rd(dsp_rd), .a_addr(dsp_addr), .a_wdata(dsp_wdata), .a_rdata(dsp_rdata),
        .b_wr(usr_wr), .b_rd(usr_rd), .b_addr(usr_addr), .b_wdata(usr_wdata), .b_rdata(usr_rdata),
        .pins_q(pins_q), .data_q(data_q), .dir_q(dir_q)
    );

    gpio_padmux #(.NPIN(NPIN)) i_padmux (
        .data_q(data_q), .dir_q(dir_q), .alt_en(alt_en), .alt_out(alt_out),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
    );

    // R2: private pins stay driven whatever either master writes
    p_priv_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & PRIV_MASK) == PRIV_MASK));
endmodule

// File: tb/test_dual_gpio_port.sv
`timescale 1ns/1ps
module test_dual_gpio_port;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       dsp_wr = 0, dsp_rd = 0, usr_wr = 0, usr_rd = 0;
    logic [1:0] dsp_addr = 0, usr_addr = 0;
    logic [6:0] dsp_wdata = 0, usr_wdata = 0, alt_en = 0, alt_out = 0, pad_in = 0;
    logic [6:0] dsp_rdata, usr_rdata, pad_out, pad_oe, pad_pullup;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    dual_gpio_port i_dual_gpio_port (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic a_write(input logic [1:0] ad, input logic [6:0] v);
        dsp_wr = 1; dsp_addr = ad; dsp_wdata = v; tick(); dsp_wr = 0;
    endtask

    task automatic b_write(input logic [1:0] ad, input logic [6:0] v);
        usr_wr = 1; usr_addr = ad; usr_wdata = v; tick(); usr_wr = 0;
    endtask

    task automatic a_read(input logic [1:0] ad, output logic [6:0] v);
        dsp_rd = 1; dsp_addr = ad; #0.5; v = dsp_rdata; dsp_rd = 0; #0.1;
    endtask

    task automatic b_read(input logic [1:0] ad, output logic [6:0] v);
        usr_rd = 1; usr_addr = ad; #0.5; v = usr_rdata; usr_rd = 0; #0.1;
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] rv, dirv, p, e, ao;
        repeat (3) tick();
        rst_n = 1; tick();

        // R1 reset state
        chk("R1 oe", pad_oe, 7'b1100000);
        chk("R1 out hi", pad_out & 7'h60, 7'h60);
        chk("R1 pullup", pad_pullup, 7'b0011111);
        a_read(2'd0, rv); chk("R1 data", rv, 7'b1100000);
        a_read(2'd1, rv); chk("R1 dir", rv, 7'b1100000);

        // R6 R2 R3 R4: primary master full sweep
        for (int v = 0; v < 128; v++) begin
            dirv = 7'(v) ^ 7'h55;
            a_write(2'd0, 7'(v));
            a_write(2'd1, dirv);
            chk("R3 out", pad_out, 7'(v));
            chk("R2 oe", pad_oe, dirv | 7'h60);
            chk("R4 pullup", pad_pullup, ~(dirv | 7'h60));
            a_read(2'd0, rv); chk("R6 data rb", rv, 7'(v));
            a_read(2'd1, rv); chk("R6 dir rb", rv, dirv | 7'h60);
        end

        // R5: secondary master sweep over preset private values
        for (int pv = 0; pv < 4; pv++) begin
            p = {2'(pv), 5'b10101};
            a_write(2'd0, p);
            a_write(2'd1, 7'h00);
            for (int v = 0; v < 128; v++) begin
                b_write(2'd0, 7'(v));
                chk("R5 out", pad_out, (p & 7'h60) | (7'(v) & 7'h1f));
                b_read(2'd0, rv); chk("R5 rd mask", rv, 7'(v) & 7'h1f);
                b_write(2'd1, 7'(v));
                chk("R5 oe", pad_oe, 7'h60 | (7'(v) & 7'h1f));
                b_read(2'd1, rv); chk("R5 dir mask", rv, 7'(v) & 7'h1f);
            end
        end

        // R3 R2: alternate-function sweep
        a_write(2'd0, 7'h2a);
        a_write(2'd1, 7'h00);
        for (int v = 0; v < 128; v++) begin
            e = 7'(v); ao = 7'(v * 3) ^ 7'h4c;
            alt_en = e; alt_out = ao; #0.5;
            chk("R3 alt out", pad_out, (e & ao) | (~e & 7'h2a));
            chk("R2 alt oe", pad_oe, e | 7'h60);
            chk("R4 alt pullup", pad_pullup, ~(e | 7'h60));
            tick();
        end
        alt_en = 0; alt_out = 0;

        // R7: collisions
        for (int v = 0; v < 16; v++) begin
            dsp_wr = 1; usr_wr = 1; dsp_addr = 2'd0; usr_addr = 2'd0;
            dsp_wdata = 7'(v * 9); usr_wdata = ~7'(v * 9);
            tick(); dsp_wr = 0; usr_wr = 0;
            a_read(2'd0, rv); chk("R7 same reg", rv, 7'(v * 9));
            dsp_wr = 1; usr_wr = 1; dsp_addr = 2'd0; usr_addr = 2'd1;
            dsp_wdata = 7'(v * 5); usr_wdata = 7'(v * 7);
            tick(); dsp_wr = 0; usr_wr = 0;
            a_read(2'd0, rv); chk("R7 diff data", rv, 7'(v * 5));
            a_read(2'd1, rv); chk("R7 diff dir", rv, (7'(v * 7) & 7'h1f) | 7'h60);
        end

        // R8: synchronizer latency
        pad_in = 0; tick(); tick(); tick();
        for (int v = 1; v < 128; v++) begin
            pad_in = 7'(v);
            tick();
            a_read(2'd2, rv); chk("R8 one edge", rv, 7'(v - 1));
            tick();
            a_read(2'd2, rv); chk("R8 two edges", rv, 7'(v));
            b_read(2'd2, rv); chk("R8 R5 b pins", rv, 7'(v) & 7'h1f);
        end

        // R9: idle strobes and unused address
        a_write(2'd0, 7'h33);
        dsp_addr = 2'd0; #0.5; chk("R9 a idle", dsp_rdata, 7'h00);
        usr_addr = 2'd0; #0.5; chk("R9 b idle", usr_rdata, 7'h00);
        a_write(2'd3, 7'h7f); b_write(2'd3, 7'h7f);
        a_read(2'd3, rv); chk("R9 addr3", rv, 7'h00);
        a_read(2'd0, rv); chk("R9 data kept", rv, 7'h33);
        chk("R9 out kept", pad_out, 7'h33);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule